// File: doc/BRIEF.md
# Transmit Retry Flag Clear Control

This block keeps one sticky transmit-retry flag for each of four transmit ports. A retry event from a port's transmit engine sets that port's flag. The flag stays set until software clears it with an addressed handshake. While the flag is set, the block refuses new packet writes into that port's transmit buffer. Each flag also drives its own retry pin. The pin driver is enabled only while the active-low interrupt-enable input is held low.

To clear a flag, the controller does three things:
- points the binary port select at the port,
- holds the enable low,
- raises the clear strobe for one or more transfer clock cycles.

The clear happens once, on the first clock edge of the strobe pulse. The select and the enable must stay unchanged while the strobe is high. If either one moves during the pulse, a sticky protocol-error output is raised.

Top module: `txr_flag_ctl`

## Requirements
- R1: Each port owns one flag. A high `retry_set` bit for port k at a clock edge sets flag k. The flag then stays at 1 until a clear or a reset. `retry_pin[k]` always shows flag k.
- R2: Every bit of `retry_pin_oe` is 1 exactly while `irq_en_n` is 0, and 0 while it is 1.
- R3: Suppose `clr_stb` is sampled high at an edge, was low at the edge before, and `irq_en_n` is 0. Then the flag of the port whose index equals the binary value of `port_sel` (value k selects bit k) reads 0 after that edge. Flags of the other ports are unchanged.
- R4: If `irq_en_n` is 1 at the first edge of a strobe pulse, that pulse clears no flag.
- R5: A pulse clears at most once. A flag that is set while the strobe stays high remains set.
- R6: Suppose `clr_stb` is high at two consecutive edges, and `port_sel` or `irq_en_n` differs between them. Then `proto_err` reads 1 after the second edge and stays 1 until reset.
- R7: If a set and a clear reach the same port at the same edge, the flag ends at 1.
- R8: `wr_block[k]` equals flag k.
- R9: If `wr_req[k]` is high at an edge where flag k is 1, `wr_reject[k]` is 1 for the following cycle. Otherwise `wr_reject[k]` is 0 in that cycle.
- R10: While `rst_n` is low, all flags, `proto_err` and `wr_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retry_set | input | 4 | Per-port retry event pulse |
| port_sel | input | 2 | Binary index of the port to clear |
| irq_en_n | input | 1 | Active-low pin-driver and clear enable |
| clr_stb | input | 1 | Clear strobe |
| wr_req | input | 4 | Per-port packet write attempt |
| retry_pin | output | 4 | Retry pin value per port |
| retry_pin_oe | output | 4 | Retry pin driver enable per port |
| wr_block | output | 4 | Per-port write refusal level |
| wr_reject | output | 4 | One-cycle reject pulse per refused write |
| proto_err | output | 1 | Sticky strobe-stability violation flag |

## Verification
The bench aims at these corner cases:
- A strobe that is held for several cycles. A design that re-clears each cycle would wipe a retry that arrived mid-pulse.
- A set and a clear colliding on one port. A clear-priority design would lose the retry.
- A pulse that begins with the enable high. A level-sensitive design would clear it anyway.
- A select or enable that moves during a pulse. A missing comparison leaves `proto_err` low.
- An unselected port during a clear. Wrong decoding disturbs its flag.

Writes to blocked and unblocked ports are mixed to catch a reject that is stuck or shifted by a cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned TXR_PORTS = 4;
  localparam int unsigned TXR_SELW  = (TXR_PORTS > 1) ? $clog2(TXR_PORTS) : 1;

  // next value of one retry flag; a set always beats a clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // true when the held controls moved between two strobe-high samples
  function automatic logic ctl_moved(logic [TXR_SELW-1:0] sel_now,
                                     logic [TXR_SELW-1:0] sel_old,
                                     logic en_now, logic en_old);
    return (sel_now != sel_old) || (en_now != en_old);
  endfunction
endpackage

// File: rtl/txr_clear_seq.sv
module txr_clear_seq #(
  parameter int unsigned NPORT = txr_pkg::TXR_PORTS,
  parameter int unsigned SELW  = txr_pkg::TXR_SELW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SELW-1:0]  port_sel,
  input  logic             irq_en_n,
  input  logic             clr_stb,
  output logic             clr_fire,
  output logic [NPORT-1:0] clr_vec,
  output logic             viol,
  output logic             proto_err
);
  logic            stb_q;
  logic [SELW-1:0] sel_q;
  logic            en_q;
  logic            err_q;
  logic            pulse_start;
  logic            in_pulse;

  assign pulse_start = clr_stb & ~stb_q;
  assign in_pulse    = clr_stb & stb_q;
  assign clr_fire    = pulse_start & ~irq_en_n;
  assign viol        = in_pulse & txr_pkg::ctl_moved(port_sel, sel_q, irq_en_n, en_q);
  assign proto_err   = err_q;

  always_comb begin
    for (int i = 0; i < int'(NPORT); i++) begin
      clr_vec[i] = clr_fire && (int'(port_sel) == i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      sel_q <= '0;
      en_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      stb_q <= clr_stb;
      sel_q <= port_sel;
      en_q  <= irq_en_n;
      if (viol) err_q <= 1'b1;
    end
  end

  // R5: one clear per pulse
  p_single_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> !clr_fire);
  // R6: a detected violation reaches the error output
  p_viol_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> proto_err);
  // R6: error is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R3: at most one port addressed
  p_clr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/txr_flag_bank.sv
module txr_flag_bank #(
  parameter int unsigned NPORT = txr_pkg::TXR_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] retry_set,
  input  logic [NPORT-1:0] clr_vec,
  output logic [NPORT-1:0] flags
);
  for (genvar g = 0; g < int'(NPORT); g++) begin : g_port
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= txr_pkg::flag_next(flag_q, retry_set[g], clr_vec[g]);
    end
    assign flags[g] = flag_q;

    // R7: set wins
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      retry_set[g] |=> flags[g]);
    // R3: addressed clear without set empties the flag
    p_clear_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !retry_set[g]) |=> !flags[g]);
    // R1: flag is sticky otherwise
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!retry_set[g] && !clr_vec[g]) |=> $stable(flags[g]));
  end
endmodule

// File: rtl/txr_write_gate.sv
module txr_write_gate #(
  parameter int unsigned NPORT = txr_pkg::TXR_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] flags,
  input  logic [NPORT-1:0] wr_req,
  output logic [NPORT-1:0] wr_block,
  output logic [NPORT-1:0] wr_reject
);
  logic [NPORT-1:0] rej_q;

  assign wr_block  = flags;
  assign wr_reject = rej_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= '0;
    else        rej_q <= wr_req & flags;
  end

  for (genvar g = 0; g < int'(NPORT); g++) begin : g_chk
    // R9: a reject only follows a write to a blocked port
    p_reject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject[g] |-> $past(wr_req[g] && flags[g]));
  end
endmodule

// File: rtl/txr_flag_ctl.sv
module txr_flag_ctl #(
  parameter int unsigned NPORT = txr_pkg::TXR_PORTS,
  parameter int unsigned SELW  = txr_pkg::TXR_SELW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] retry_set,
  input  logic [SELW-1:0]  port_sel,
  input  logic             irq_en_n,
  input  logic             clr_stb,
  input  logic [NPORT-1:0] wr_req,
  output logic [NPORT-1:0] retry_pin,
  output logic [NPORT-1:0] retry_pin_oe,
  output logic [NPORT-1:0] wr_block,
  output logic [NPORT-1:0] wr_reject,
  output logic             proto_err
);
  logic             clr_fire;
  logic [NPORT-1:0] clr_vec;
  logic             viol;
  logic [NPORT-1:0] flags;

  txr_clear_seq #(.NPORT(NPORT), .SELW(SELW)) u_seq (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .irq_en_n(irq_en_n),
    .clr_stb(clr_stb), .clr_fire(clr_fire), .clr_vec(clr_vec),
    .viol(viol), .proto_err(proto_err));

  txr_flag_bank #(.NPORT(NPORT)) u_bank (
    .clk(clk), .rst_n(rst_n), .retry_set(retry_set), .clr_vec(clr_vec),
    .flags(flags));

  txr_write_gate #(.NPORT(NPORT)) u_gate (
    .clk(clk), .rst_n(rst_n), .flags(flags), .wr_req(wr_req),
    .wr_block(wr_block), .wr_reject(wr_reject));

  assign retry_pin    = flags;
  assign retry_pin_oe = {NPORT{~irq_en_n}};

  // R6: a violation cycle never fires a clear
  p_viol_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !clr_fire);
  // R4: driver enable and clear eligibility agree
  p_fire_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |-> (retry_pin_oe != '0));
endmodule

// File: tb/txr_flag_ctl_tb_top.sv
module txr_flag_ctl_tb_top;
  localparam int NP = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] retry_set, wr_req;
  logic [SW-1:0] port_sel;
  logic          irq_en_n, clr_stb;
  logic [NP-1:0] retry_pin, retry_pin_oe, wr_block, wr_reject;
  logic          proto_err;

  txr_flag_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .retry_set(retry_set), .port_sel(port_sel),
    .irq_en_n(irq_en_n), .clr_stb(clr_stb), .wr_req(wr_req),
    .retry_pin(retry_pin), .retry_pin_oe(retry_pin_oe), .wr_block(wr_block),
    .wr_reject(wr_reject), .proto_err(proto_err));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [NP-1:0] m_flag, m_rej;
  logic          m_err, m_pstb, m_pen;
  logic [SW-1:0] m_psel;

  function automatic logic [NP-1:0] f_clear_mask(logic stb, logic pstb, logic en_n,
                                                 logic [SW-1:0] sel);
    logic [NP-1:0] v = '0;
    if (stb && !pstb && !en_n) v = NP'(1) << sel;
    return v;
  endfunction

  function automatic logic f_violation(logic stb, logic pstb, logic [SW-1:0] sel,
                                       logic [SW-1:0] psel, logic en_n, logic pen);
    return stb && pstb && ((sel != psel) || (en_n != pen));
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 retry pins", 32'(retry_pin), 32'(m_flag));
    chk("R8 write block", 32'(wr_block), 32'(m_flag));
    chk("R9 reject", 32'(wr_reject), 32'(m_rej));
    chk("R6 proto err", 32'(proto_err), 32'(m_err));
    chk("R2 pin enable", 32'(retry_pin_oe), 32'({NP{~irq_en_n}}));
  endtask

  task automatic step(logic [NP-1:0] set, logic [SW-1:0] sel, logic en_n,
                      logic stb, logic [NP-1:0] wr);
    logic [NP-1:0] cm;
    retry_set = set; port_sel = sel; irq_en_n = en_n; clr_stb = stb; wr_req = wr;
    cm     = f_clear_mask(stb, m_pstb, en_n, sel);
    m_err  = m_err | f_violation(stb, m_pstb, sel, m_psel, en_n, m_pen);
    m_rej  = wr & m_flag;
    m_flag = set | (m_flag & ~cm);
    m_pstb = stb; m_psel = sel; m_pen = en_n;
    @(posedge clk);
    #2;
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; retry_set = '0; wr_req = '0; port_sel = '0;
    irq_en_n = 1'b1; clr_stb = 1'b0;
    m_flag = '0; m_rej = '0; m_err = 1'b0; m_pstb = 1'b0; m_psel = '0; m_pen = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R10 flags in reset", 32'(retry_pin), 0);
    chk("R10 reject in reset", 32'(wr_reject), 0);
    chk("R10 err in reset", 32'(proto_err), 0);
    rst_n = 1'b1;
  endtask

  task automatic random_run(int cycles, bit allow_moves);
    logic [SW-1:0] sel = '0;
    logic en_n = 1'b0;
    logic stb = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      logic [NP-1:0] set, wr;
      for (int b = 0; b < NP; b++) begin
        set[b] = ($urandom % 8) == 0;
        wr[b]  = ($urandom % 3) == 0;
      end
      if (($urandom % 3) == 0) stb = ~stb;
      if (!stb || (allow_moves && ($urandom % 6) == 0)) begin
        if (($urandom % 2) == 0) sel = SW'($urandom);
        if (($urandom % 4) == 0) en_n = ~en_n;
      end
      step(set, sel, en_n, stb, wr);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: set port 2, then hold
    step(4'b0100, 2'd0, 1'b1, 1'b0, 4'b0000);
    chk("R1 set port2", 32'(retry_pin), 32'h4);
    step(4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000);
    chk("R1 hold port2", 32'(retry_pin), 32'h4);
    // R9: writes to blocked port 2 and free port 1
    step(4'b0000, 2'd0, 1'b1, 1'b0, 4'b0110);
    chk("R9 reject only port2", 32'(wr_reject), 32'h4);
    step(4'b0000, 2'd0, 1'b1, 1'b0, 4'b0000);
    chk("R9 reject ends", 32'(wr_reject), 32'h0);
    // R4: strobe with enable high does not clear
    step(4'b0000, 2'd2, 1'b1, 1'b1, 4'b0000);
    chk("R4 no clear when disabled", 32'(retry_pin), 32'h4);
    step(4'b0000, 2'd2, 1'b1, 1'b0, 4'b0000);
    // R3: proper clear of port 2 leaves port 0 untouched
    step(4'b0001, 2'd2, 1'b0, 1'b0, 4'b0000);
    step(4'b0000, 2'd2, 1'b0, 1'b1, 4'b0000);
    chk("R3 port2 cleared port0 kept", 32'(retry_pin), 32'h1);
    // R5: set during held pulse survives
    step(4'b0100, 2'd2, 1'b0, 1'b1, 4'b0000);
    step(4'b0000, 2'd2, 1'b0, 1'b1, 4'b0000);
    chk("R5 no second clear", 32'(retry_pin), 32'h5);
    step(4'b0000, 2'd2, 1'b0, 1'b0, 4'b0000);
    // R7: set and clear same edge
    step(4'b0100, 2'd2, 1'b0, 1'b1, 4'b0000);
    chk("R7 set wins", 32'(retry_pin), 32'h5);
    chk("R6 no error yet", 32'(proto_err), 0);
    step(4'b0000, 2'd2, 1'b0, 1'b0, 4'b0000);
    random_run(3000, 1'b0);
    chk("R6 stable run no error", 32'(proto_err), 0);

    do_reset();
    // R6: select moves while strobe high
    step(4'b0000, 2'd1, 1'b0, 1'b1, 4'b0000);
    step(4'b0000, 2'd3, 1'b0, 1'b1, 4'b0000);
    chk("R6 select move flagged", 32'(proto_err), 1);
    step(4'b0000, 2'd3, 1'b0, 1'b0, 4'b0000);
    chk("R6 error sticky", 32'(proto_err), 1);
    do_reset();
    // R6: enable moves while strobe high
    step(4'b0000, 2'd1, 1'b1, 1'b1, 4'b0000);
    step(4'b0000, 2'd1, 1'b0, 1'b1, 4'b0000);
    chk("R6 enable move flagged", 32'(proto_err), 1);
    step(4'b0000, 2'd1, 1'b0, 1'b0, 4'b0000);
    random_run(3000, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule